// File: doc/BRIEF.md
# Registered Sum-of-Products Logic Array

This block is a field-configurable logic element. A link store decides, for every product term, which literals take part in it. The literals are the true and inverted forms of eight dedicated inputs and of eight feedback signals. Each output takes the OR of its own group of eight product terms. In the default build every output is captured by a D flip-flop on the rising clock edge. The pin level is the inverse of the flop, and that same inverted level feeds back into the array. This makes multi-state machines possible inside one block.

A single active-low enable input controls the three-state enables of all registered outputs. A preload input lets test logic force any register state, including states the programmed logic can never reach, and then watch how the machine leaves them. An asynchronous power-on reset clears every flop, so every registered pin comes up HIGH.

The configuration port writes one product term's link mask per clock and reads back the mask at the addressed term. A sticky lock bit hides the readback until the next power-on reset. The `NUM_REG` parameter can reduce the number of registered outputs to 6 or 4. The outputs that are not registered, at the outer positions, then become combinational bidirectional pins: one term of their group drives the enable and the other seven form the sum.

Top module: `pla_reg_array`

## Requirements
- R1: While `rst_ni` is low, every flop is cleared, so every registered bit of `pins_o` reads 1. Reset acts without a clock edge.
- R2: On each rising edge with reset released and preload low, a registered output's flop loads the OR of its eight terms; output j owns terms 8j to 8j+7. `pins_o[j]` shows the inverse of the flop after that edge.
- R3: Literal column 2k carries signal k and column 2k+1 carries its inverse. Signals 0-7 are `in_i[0..7]` and signals 8-15 are the feedback of outputs 0-7. A term is 1 when every column whose link bit is 1 carries a 1. So a term with no links set is 1, and a term linking both columns of one signal is 0.
- R4: The feedback of a registered output is its pin level (inverted flop), whatever the value of `oe_ni`.
- R5: `oe_ni` low sets, and `oe_ni` high clears, `pins_oe_o` for every registered output. It does not change `pins_o` or the register contents.
- R6: With `preload_i` high at a rising edge, every registered output shows `preload_data_i[j]` on `pins_o[j]` after that edge, in place of the array result.
- R7: `cfg_we_i` high at a rising edge stores `cfg_wdata_i` as the link mask of term `cfg_addr_i`. Bit c of the mask is the link to literal column c. The new mask is used from the next edge on.
- R8: `cfg_rdata_o` shows the mask of term `cfg_addr_i` while unlocked. After a rising edge with `cfg_lock_i` high it reads all zeros until `rst_ni` goes low. Writes still take effect while locked.
- R9: With `NUM_REG` below 8, the (8-NUM_REG)/2 lowest and highest outputs are combinational. Such a pin drives the inverse of the OR of terms 8j+1..8j+7, term 8j drives its enable, and its feedback columns take `pins_i[j]`.
- R10: A power-on reset in mid-operation clears the flops and the lock but keeps all link masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| in_i | input | 8 | Dedicated array inputs |
| oe_ni | input | 1 | Active-low enable for all registered outputs |
| preload_i | input | 1 | Load registers from preload data at the next edge |
| preload_data_i | input | 8 | Pin levels to force during preload |
| pins_i | input | 8 | Pad levels sensed for combinational outputs |
| pins_o | output | 8 | Output pin levels (active-low of the flops) |
| pins_oe_o | output | 8 | Three-state enable per output pin |
| cfg_we_i | input | 1 | Link mask write strobe |
| cfg_addr_i | input | 6 | Product term index |
| cfg_wdata_i | input | 32 | Link mask to write |
| cfg_lock_i | input | 1 | Set the readback lock |
| cfg_rdata_o | output | 32 | Link mask readback, zero when locked |

## Verification
The hardest situation to reach from the ports is a register state that the programmed equations never produce, followed by a check that the machine recovers from it. Preload writes such a state directly. The bench then drops preload and follows the state from the inverted feedback through several clocks. A second difficulty is the combinational variant: its feedback comes from the pad and not from the array. A second instance, built with four registered outputs, runs under the same configuration while its pad inputs are driven on their own. Randomly written masks, including contradictory and empty terms, are then compared against a model computed from the literal rules.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;
  parameter int NUM_IN   = 8;
  parameter int NUM_OUT  = 8;
  parameter int TPO      = 8;
  localparam int NUM_SIG  = NUM_IN + NUM_OUT;
  localparam int NUM_COL  = 2 * NUM_SIG;
  localparam int NUM_TERM = NUM_OUT * TPO;
  localparam int ADDR_W   = $clog2(NUM_TERM);

  typedef logic [NUM_COL-1:0] col_t;

  // registered outputs sit in the middle, combinational ones at both ends
  function automatic logic [NUM_OUT-1:0] reg_mask(int num_reg);
    int ncomb, lo, hi;
    logic [NUM_OUT-1:0] m;
    ncomb = NUM_OUT - num_reg;
    lo    = ncomb / 2;
    hi    = NUM_OUT - (ncomb - lo);
    for (int j = 0; j < NUM_OUT; j++) m[j] = (j >= lo) && (j < hi);
    return m;
  endfunction
endpackage

// File: rtl/pla_link_store.sv
`timescale 1ns/1ps
module pla_link_store
  import pla_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  col_t                             wdata_i,
  input  logic                             lock_i,
  output col_t                             rdata_o,
  output logic                             locked_o,
  output logic [NUM_TERM-1:0][NUM_COL-1:0] links_o
);
  logic [NUM_TERM-1:0][NUM_COL-1:0] links_q;
  logic                             lock_q;

  // link masks model non-volatile storage: no reset
  always_ff @(posedge clk_i) begin
    if (we_i) links_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lock_q <= 1'b0;
    else if (lock_i) lock_q <= 1'b1;
  end

  assign rdata_o  = lock_q ? '0 : links_q[addr_i];
  assign locked_o = lock_q;
  assign links_o  = links_q;
endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane
  import pla_pkg::*;
(
  input  logic [NUM_IN-1:0]                in_i,
  input  logic [NUM_OUT-1:0]               fb_i,
  input  logic [NUM_TERM-1:0][NUM_COL-1:0] links_i,
  output logic [NUM_TERM-1:0]              terms_o
);
  logic [NUM_SIG-1:0] sig_w;
  col_t               lits_w;

  assign sig_w = {fb_i, in_i};

  for (genvar k = 0; k < NUM_SIG; k++) begin : g_lit
    assign lits_w[2*k]   = sig_w[k];
    assign lits_w[2*k+1] = ~sig_w[k];
  end

  // a linked column that carries 0 kills the term
  for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
    assign terms_o[t] = ~|(links_i[t] & ~lits_w);
  end
endmodule

// File: rtl/pla_macrocell.sv
`timescale 1ns/1ps
module pla_macrocell #(
  parameter bit IS_REG = 1'b1,
  parameter int TPO    = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [TPO-1:0] terms_i,
  input  logic           oe_ni,
  input  logic           preload_i,
  input  logic           preload_bit_i,
  input  logic           pin_i,
  output logic           pin_o,
  output logic           pin_oe_o,
  output logic           fb_o,
  output logic           sum_o
);
  if (IS_REG) begin : g_reg
    logic q;
    logic unused_pin;
    assign sum_o = |terms_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= 1'b0;
      else if (preload_i) q <= ~preload_bit_i;
      else                q <= sum_o;
    end
    assign pin_o      = ~q;
    assign pin_oe_o   = ~oe_ni;
    assign fb_o       = ~q;
    assign unused_pin = pin_i;
  end else begin : g_comb
    logic unused_ctl;
    assign sum_o      = |terms_i[TPO-1:1];
    assign pin_o      = ~sum_o;
    assign pin_oe_o   = terms_i[0];
    assign fb_o       = pin_i;
    assign unused_ctl = clk_i ^ rst_ni ^ oe_ni ^ preload_i ^ preload_bit_i;
  end
endmodule

// File: rtl/pla_reg_array.sv
`timescale 1ns/1ps
module pla_reg_array
  import pla_pkg::*;
#(
  parameter int NUM_REG = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IN-1:0]    in_i,
  input  logic                 oe_ni,
  input  logic                 preload_i,
  input  logic [NUM_OUT-1:0]   preload_data_i,
  input  logic [NUM_OUT-1:0]   pins_i,
  output logic [NUM_OUT-1:0]   pins_o,
  output logic [NUM_OUT-1:0]   pins_oe_o,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [NUM_COL-1:0]   cfg_wdata_i,
  input  logic                 cfg_lock_i,
  output logic [NUM_COL-1:0]   cfg_rdata_o
);
  localparam logic [NUM_OUT-1:0] REG_MASK = reg_mask(NUM_REG);

  logic [NUM_TERM-1:0][NUM_COL-1:0] links_w;
  logic [NUM_TERM-1:0]              terms_w;
  logic [NUM_OUT-1:0]               fb_w;
  logic [NUM_OUT-1:0]               sum_w;
  logic                             locked_w;

  pla_link_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .lock_i  (cfg_lock_i),
    .rdata_o (cfg_rdata_o),
    .locked_o(locked_w),
    .links_o (links_w)
  );

  pla_and_plane u_plane (
    .in_i   (in_i),
    .fb_i   (fb_w),
    .links_i(links_w),
    .terms_o(terms_w)
  );

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_cell
    pla_macrocell #(.IS_REG(REG_MASK[j]), .TPO(TPO)) u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .terms_i      (terms_w[j*TPO +: TPO]),
      .oe_ni        (oe_ni),
      .preload_i    (preload_i),
      .preload_bit_i(preload_data_i[j]),
      .pin_i        (pins_i[j]),
      .pin_o        (pins_o[j]),
      .pin_oe_o     (pins_oe_o[j]),
      .fb_o         (fb_w[j]),
      .sum_o        (sum_w[j])
    );
  end
endmodule

// File: rtl/pla_reg_array_chk.sv
`timescale 1ns/1ps
module pla_reg_array_chk #(
  parameter logic [7:0] REG_MASK = 8'hFF
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        oe_ni,
  input logic        preload_i,
  input logic [7:0]  preload_data_i,
  input logic [7:0]  pins_o,
  input logic [7:0]  pins_oe_o,
  input logic [7:0]  sum_w,
  input logic        cfg_we_i,
  input logic [5:0]  cfg_addr_i,
  input logic [31:0] cfg_wdata_i,
  input logic        cfg_lock_i,
  input logic [31:0] cfg_rdata_o,
  input logic        locked_w
);
  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_high: assert ((pins_o & REG_MASK) == REG_MASK);
  end

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preload_i |=> ((pins_o & REG_MASK) == (~$past(sum_w) & REG_MASK)));

  a_r5_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> ((pins_oe_o & REG_MASK) == 8'h00));

  a_r6_preload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_i |=> ((pins_o & REG_MASK) == ($past(preload_data_i) & REG_MASK)));

  a_r7_write_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !locked_w && !cfg_lock_i) |=>
      (!$stable(cfg_addr_i) || cfg_rdata_o == $past(cfg_wdata_i)));

  a_r8_lock_hides: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_lock_i |=> (cfg_rdata_o == 32'h0));

  a_r8_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_w |=> locked_w);
endmodule

bind pla_reg_array pla_reg_array_chk #(.REG_MASK(REG_MASK)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .oe_ni         (oe_ni),
  .preload_i     (preload_i),
  .preload_data_i(preload_data_i),
  .pins_o        (pins_o),
  .pins_oe_o     (pins_oe_o),
  .sum_w         (sum_w),
  .cfg_we_i      (cfg_we_i),
  .cfg_addr_i    (cfg_addr_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .cfg_lock_i    (cfg_lock_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .locked_w      (locked_w)
);

// File: tb/pla_reg_array_tb_top.sv
`timescale 1ns/1ps
module pla_reg_array_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_v = '0;
  logic        oe_n = 1'b0;
  logic        pl = 1'b0;
  logic [7:0]  pld = '0;
  logic [7:0]  pin4 = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        lock = 1'b0;

  logic [7:0]  pin8_o, oe8_o, pin4_o, oe4_o;
  logic [31:0] rd8_o, rd4_o;

  localparam logic [7:0] REG4 = 8'h3C;

  always #10 clk = ~clk;

  pla_reg_array #(.NUM_REG(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_v), .oe_ni(oe_n), .preload_i(pl),
    .preload_data_i(pld), .pins_i(8'h00), .pins_o(pin8_o), .pins_oe_o(oe8_o),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_lock_i(lock),
    .cfg_rdata_o(rd8_o));

  pla_reg_array #(.NUM_REG(4)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_v), .oe_ni(oe_n), .preload_i(pl),
    .preload_data_i(pld), .pins_i(pin4), .pins_o(pin4_o), .pins_oe_o(oe4_o),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_lock_i(lock),
    .cfg_rdata_o(rd4_o));

  typedef struct {
    int          cyc;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          cyc = 0;
  int          tests = 0;
  int          fails = 0;
  logic [31:0] bm [64];
  logic [7:0]  s8 = '0, s4 = '0;
  logic        locked_m = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] actual(int sel);
    case (sel)
      0: return {24'h0, pin8_o};
      1: return {24'h0, oe8_o};
      2: return rd8_o;
      3: return {24'h0, pin4_o};
      default: return {24'h0, oe4_o};
    endcase
  endfunction

  function automatic string sel_name(int sel);
    case (sel)
      0: return "pins8"; 1: return "oe8"; 2: return "rdata";
      3: return "pins4"; default: return "oe4";
    endcase
  endfunction

  function automatic logic [63:0] eval(logic [7:0] iv, logic [7:0] fb);
    logic [31:0] lits;
    logic [63:0] r;
    for (int k = 0; k < 16; k++) begin
      logic s;
      s = (k < 8) ? iv[k] : fb[k-8];
      lits[2*k]   = s;
      lits[2*k+1] = ~s;
    end
    for (int t = 0; t < 64; t++) r[t] = ((bm[t] & ~lits) == 32'h0);
    return r;
  endfunction

  function automatic logic [7:0] fb4(logic [7:0] st, logic [7:0] pads);
    return (~st & REG4) | (pads & ~REG4);
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic push(int sel, logic [31:0] exp, string tag);
    item_t it;
    it.cyc = cyc + 1; it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic check_now(int sel, logic [31:0] msk, logic [31:0] exp, string tag);
    logic [31:0] a;
    a = actual(sel) & msk;
    tests++;
    if (a !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, sel_name(sel), a, exp);
    end
  endtask

  // called at a falling edge with stimulus already set
  task automatic step(string tag);
    logic [63:0] t8, t4, t4p;
    logic [7:0]  n8, n4, e4, o4;
    t8 = eval(in_v, ~s8);
    t4 = eval(in_v, fb4(s4, pin4));
    for (int j = 0; j < 8; j++) begin
      n8[j] = |t8[8*j +: 8];
      n4[j] = REG4[j] ? |t4[8*j +: 8] : 1'b0;
    end
    if (pl) begin n8 = ~pld; n4 = ~pld & REG4; end
    if (!rst_n) begin n8 = '0; n4 = '0; end
    if (we) bm[addr] = wdata;
    if (!rst_n) locked_m = 1'b0; else if (lock) locked_m = 1'b1;
    s8 = n8; s4 = n4;
    t4p = eval(in_v, fb4(s4, pin4));
    for (int j = 0; j < 8; j++) begin
      e4[j] = REG4[j] ? ~s4[j] : ~(|t4p[8*j+1 +: 7]);
      o4[j] = REG4[j] ? ~oe_n  : t4p[8*j];
    end
    push(0, {24'h0, ~s8}, tag);
    push(1, {24'h0, {8{~oe_n}}}, tag);
    push(2, locked_m ? 32'h0 : bm[addr], tag);
    push(3, {24'h0, e4}, tag);
    push(4, {24'h0, o4}, tag);
    @(negedge clk);
  endtask

  task automatic cfg_wr(logic [5:0] a, logic [31:0] d, string tag);
    we = 1'b1; addr = a; wdata = d;
    step(tag);
    we = 1'b0;
  endtask

  always @(posedge clk) begin
    item_t it;
    logic [31:0] a;
    cyc++;
    #5;
    while (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
      it = sb_q.pop_front();
      a  = actual(it.sel);
      tests++;
      if (a !== it.exp) begin
        fails++;
        $display("FAIL %s %s cyc=%0d actual=%h expected=%h", it.tag,
                 sel_name(it.sel), cyc, a, it.exp);
      end
    end
  end

  initial begin
    #(20 * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] m;
    @(negedge clk);
    // R1: reset state without any clocked result yet
    check_now(0, 32'hFF, 32'hFF, "R1");
    check_now(3, REG4, {24'h0, REG4}, "R1");

    // R7: program masks under reset; registers stay cleared (R1)
    for (int t = 0; t < 64; t++) begin
      m = 32'h3;                           // in0 & ~in0: always 0 (R3)
      case (t)
        0:  m = 32'h1;                     // in0
        1:  m = 32'h4;                     // in1
        8:  m = 32'h0;                     // empty term: always 1 (R3)
        16: m = 32'h1 << 20;               // fb2 true: toggle (R4)
        24: m = (32'h1 << 4) | (32'h1 << 7);
        25: m = 32'h1 << 17;               // ~fb0
        32: m = 32'h1 << 8;
        40: m = (32'h1 << 10) | (32'h1 << 12);
        48: m = 32'h1 << 30;               // fb7
        56: m = 32'h1 << 15;
        57: m = 32'h1 << 18;               // fb1: pad sense in variant (R9)
        default: ;
      endcase
      cfg_wr(t[5:0], m, "R7");
    end

    // R2/R3/R4: run the fixed equations
    rst_n = 1'b1;
    for (int i = 0; i < 24; i++) begin
      in_v = 8'(i * 37 + 5); pin4 = 8'(i * 11); addr = 6'(i);
      step("R2");
    end
    for (int i = 0; i < 8; i++) begin
      in_v = 8'(1 << i); pin4 = ~8'(1 << i);
      step("R9");
    end

    // R5: disable registered outputs, logic keeps running (R4)
    oe_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      in_v = 8'(i * 91); step("R5");
    end
    oe_n = 1'b0;
    step("R5");

    // R6: force unreachable states, then watch recovery
    pl = 1'b1; pld = 8'hA5; in_v = 8'hFF; step("R6");
    pld = 8'h00; step("R6");
    pl = 1'b0;
    for (int i = 0; i < 6; i++) begin
      in_v = 8'(i * 13); step("R6");
    end

    // R8: lock hides readback, writes still land
    addr = 6'd16; step("R8");
    lock = 1'b1; step("R8");
    lock = 1'b0;
    cfg_wr(6'd33, 32'h0000_0400, "R8");
    for (int i = 0; i < 4; i++) begin
      addr = 6'(i * 9); in_v = 8'(i + 3); step("R8");
    end

    // R3/R7/R9: random sparse masks, random stimulus
    for (int t = 0; t < 64; t++) begin
      m = (32'h1 << (rnd() % 32)) | (32'h1 << (rnd() % 32));
      if (rnd() % 4 == 0) m = m | (32'h1 << (rnd() % 32));
      if (rnd() % 16 == 0) m = 32'h0;
      cfg_wr(t[5:0], m, "R7");
    end
    for (int i = 0; i < 150; i++) begin
      in_v = rnd()[7:0]; pin4 = rnd()[7:0]; oe_n = (rnd() % 5 == 0);
      pl = (rnd() % 11 == 0); pld = rnd()[7:0]; addr = rnd()[5:0];
      step("R3");
    end
    pl = 1'b0; oe_n = 1'b0;

    // R10: asynchronous reset mid-run, masks kept, lock cleared
    addr = 6'd5;
    #3 rst_n = 1'b0;
    #2;
    s8 = '0; s4 = '0; locked_m = 1'b0;
    check_now(0, 32'hFF, 32'hFF, "R10");
    check_now(3, REG4, {24'h0, REG4}, "R10");
    check_now(2, 32'hFFFF_FFFF, bm[5], "R10");
    @(negedge clk);
    step("R10");
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      in_v = rnd()[7:0]; pin4 = rnd()[7:0]; addr = 6'(i);
      step("R10");
    end

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule